// File: doc/BRIEF.md
# Multi-State Debug Trigger Sequencer

This block is the trigger engine of an on-chip logic analyzer. It watches twelve wide observation buses and runs a four-state sequencer. While a state is current, that state picks one bus, masks it, and compares it against a programmed value. The compare uses one of six unsigned relational operators. A per-state counter can qualify the move to the next state. The counter either counts qualifying events, counts cycles spent in the state, or acts as a watchdog that sends the sequencer to a separate timeout target.

Each state carries an 8-bit action word. Its bits drive outward requests such as clock stop, debug entry, trace start and stop, a trigger pulse to a neighbour, or an interrupt. Debug software programs everything through a simple word-wide write port and then arms the sequencer. The current state number and the armed flag are visible on output pins, so software can read back the status.

Top module: `dbg_trig_seq`

## Requirements
- R1: A configuration write with `cfg_addr[6]=1` sets the armed flag from `cfg_wdata[0]`. With `cfg_addr[6]=0`, `cfg_addr[5:4]` picks a state and `cfg_addr[3:0]` picks a word inside it:
  - words 0-3 hold the mask, with word 0 as bits 31:0;
  - words 4-7 hold the compare value in the same layout;
  - word 8 holds the control word;
  - word 9 holds the counter target.
- R2: Control bits [3:0] select the observed group, with group g on `grp_in[g*128 +: 128]`. Selector codes 12 to 15 observe all-zero data.
- R3: Control bits [6:4] choose the operator applied to (group & mask) against (value & mask), unsigned: 0 equal, 1 not equal, 2 greater, 3 greater or equal, 4 less, 5 less or equal. Codes 6 and 7 never match.
- R4: Control bits [8:7] give the counter mode. In mode 0, a matching cycle moves the state at that clock edge to the target in control bits [10:9]. Any target, including an earlier state or itself, is allowed.
- R5: In mode 1, each matching cycle adds one to the counter, and the state moves on the edge of the match that brings the count to the target. The counter clears whenever a transition is taken.
- R6: In mode 2, the state moves on the Nth clock edge after entry (N = target), whatever the compare result.
- R7: In mode 3, a match moves the state to the bits [10:9] target. If the target count of cycles passes with no match, the state moves to the timeout target in bits [12:11]. A match on the same edge as the timeout wins.
- R8: While disarmed, the sequencer holds state 0 with all actions low and ignores the observed data. Arming always begins in state 0.
- R9: `act_out` shows control bits [20:13] of a state starting one cycle after that state is entered. `act_out` is 0 on the first armed cycle.
- R10: `cur_state` gives the current state number, and `armed` gives the armed flag. Both read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| grp_in | input | 1536 | Twelve 128-bit observation groups, concatenated |
| act_out | output | 8 | Registered action lines of the current state |
| cur_state | output | 2 | Current trigger state |
| armed | output | 1 | Armed flag |

## Verification
Some properties are checked on every cycle:
- a disarmed sequencer returns home with quiet actions;
- the counter is zero whenever the state changes;
- a mode-0 move is always preceded by a match;
- a watchdog-mode match always lands on the normal target rather than the timeout target;
- the actions are clear on the first armed cycle.

Other behaviours need the bench's scenarios:
- the correctness of each relational operator on masked data;
- the exact edge on which an event count, a cycle count or a watchdog timeout fires;
- group selection;
- loop ordering;
- the one-cycle lag of the action lines.

// File: rtl/dts_pkg.sv
package dts_pkg;

    localparam int N_TRIG_ST = 4;
    localparam int ST_W      = 2;
    localparam int ACT_W     = 8;
    localparam int GSEL_W    = 4;
    localparam int CTRL_W    = 21;

    typedef enum logic [2:0] {
        OP_EQ  = 3'd0,
        OP_NE  = 3'd1,
        OP_GT  = 3'd2,
        OP_GE  = 3'd3,
        OP_LT  = 3'd4,
        OP_LE  = 3'd5,
        OP_NV6 = 3'd6,
        OP_NV7 = 3'd7
    } cmp_op_e;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'd0,
        MODE_EVENT  = 2'd1,
        MODE_CYCLE  = 2'd2,
        MODE_WDOG   = 2'd3
    } cnt_mode_e;

    // Packed control word; the first member lands in the top bits.
    typedef struct packed {
        logic [ACT_W-1:0]  act;
        logic [ST_W-1:0]   tmo_st;
        logic [ST_W-1:0]   nxt_st;
        cnt_mode_e         mode;
        cmp_op_e           op;
        logic [GSEL_W-1:0] gsel;
    } st_ctrl_t;

    // Reduce an equal/greater pair to the selected relation.
    function automatic logic op_eval(cmp_op_e op, logic eq, logic gt);
        logic r;
        case (op)
            OP_EQ:   r = eq;
            OP_NE:   r = !eq;
            OP_GT:   r = gt;
            OP_GE:   r = gt | eq;
            OP_LT:   r = !gt && !eq;
            OP_LE:   r = !gt;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dts_cfg_regs.sv
module dts_cfg_regs
    import dts_pkg::*;
#(
    parameter int GROUP_W = 128,
    parameter int CNT_W   = 32,
    parameter int BLK_W   = 4,
    parameter int ADDR_W  = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [GROUP_W-1:0] mask_o  [N_TRIG_ST],
    output logic [GROUP_W-1:0] match_o [N_TRIG_ST],
    output st_ctrl_t           ctrl_o  [N_TRIG_ST],
    output logic [CNT_W-1:0]   tgt_o   [N_TRIG_ST],
    output logic               arm_o
);
    localparam int WORDS = GROUP_W / 32;

    logic             glob_sel;
    logic [ST_W-1:0]  wr_st;
    logic [BLK_W-1:0] wr_word;

    assign glob_sel = addr[ADDR_W-1];
    assign wr_st    = addr[BLK_W +: ST_W];
    assign wr_word  = addr[BLK_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) arm_o <= 1'b0;
        else if (we && glob_sel) arm_o <= wdata[0];
    end

    for (genvar s = 0; s < N_TRIG_ST; s++) begin : g_st
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_o[s]  <= '0;
                match_o[s] <= '0;
                ctrl_o[s]  <= '0;
                tgt_o[s]   <= '0;
            end else if (we && !glob_sel && wr_st == ST_W'(s)) begin
                for (int w = 0; w < WORDS; w++) begin
                    if (wr_word == BLK_W'(w))         mask_o[s][w*32 +: 32]  <= wdata;
                    if (wr_word == BLK_W'(WORDS + w)) match_o[s][w*32 +: 32] <= wdata;
                end
                if (wr_word == BLK_W'(2*WORDS))     ctrl_o[s] <= st_ctrl_t'(wdata[CTRL_W-1:0]);
                if (wr_word == BLK_W'(2*WORDS + 1)) tgt_o[s]  <= wdata[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/dts_cond.sv
module dts_cond
    import dts_pkg::*;
#(
    parameter int N_GROUPS = 12,
    parameter int GROUP_W  = 128
) (
    input  logic [N_GROUPS*GROUP_W-1:0] grp_in,
    input  logic [GSEL_W-1:0]           gsel,
    input  cmp_op_e                     op,
    input  logic [GROUP_W-1:0]          mask,
    input  logic [GROUP_W-1:0]          match,
    output logic                        hit
);
    logic [GROUP_W-1:0] sel_data;
    logic [GROUP_W-1:0] lhs;
    logic [GROUP_W-1:0] rhs;

    always_comb begin
        sel_data = '0;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (gsel == GSEL_W'(g)) sel_data = grp_in[g*GROUP_W +: GROUP_W];
        end
    end

    assign lhs = sel_data & mask;
    assign rhs = match & mask;
    assign hit = op_eval(op, lhs == rhs, lhs > rhs);

    // R3: a "never" code must not report a match
    always_comb begin
        if (op == OP_NV6 || op == OP_NV7) begin
            a_never_r3: assert (!hit);
        end
    end
endmodule

// File: rtl/dts_seq_fsm.sv
module dts_seq_fsm
    import dts_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             hit,
    input  cnt_mode_e        mode,
    input  logic [ST_W-1:0]  nxt_st,
    input  logic [ST_W-1:0]  tmo_st,
    input  logic [ACT_W-1:0] act_cfg,
    input  logic [CNT_W-1:0] target,
    output logic [ST_W-1:0]  state_q,
    output logic [ACT_W-1:0] act_q
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W:0]   cnt_inc;
    logic             reach;
    logic             go;
    logic             cnt_en;
    logic [ST_W-1:0]  dest;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign reach   = cnt_inc >= {1'b0, target};

    always_comb begin
        go     = 1'b0;
        cnt_en = 1'b0;
        dest   = nxt_st;
        case (mode)
            MODE_DIRECT: go = hit;
            MODE_EVENT: begin
                cnt_en = hit;
                go     = hit && reach;
            end
            MODE_CYCLE: begin
                cnt_en = 1'b1;
                go     = reach;
            end
            MODE_WDOG: begin
                cnt_en = 1'b1;
                if (hit) begin
                    go = 1'b1;
                end else if (reach) begin
                    go   = 1'b1;
                    dest = tmo_st;
                end
            end
            default: go = 1'b0;
        endcase
        if (go)          cnt_d = '0;
        else if (cnt_en) cnt_d = cnt_inc[CNT_W-1:0];
        else             cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            state_q <= '0;
            cnt_q   <= '0;
            act_q   <= '0;
        end else begin
            if (go) state_q <= dest;
            cnt_q <= cnt_d;
            act_q <= act_cfg;
        end
    end

    p_disarm_home_r8: assert property (@(posedge clk) disable iff (rst)
        !arm |=> (state_q == '0 && act_q == '0 && cnt_q == '0));

    p_entry_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (arm && $past(arm) && state_q != $past(state_q)) |-> cnt_q == '0);

    p_direct_needs_hit_r4: assert property (@(posedge clk) disable iff (rst)
        (arm && $past(arm) && $past(mode) == MODE_DIRECT && state_q != $past(state_q))
        |-> $past(hit));

    p_wdog_hit_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (arm && $past(arm) && $past(mode) == MODE_WDOG && $past(hit))
        |-> state_q == $past(nxt_st));

    p_first_armed_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(arm) |-> act_q == '0);
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
    import dts_pkg::*;
#(
    parameter int N_GROUPS = 12,
    parameter int GROUP_W  = 128,
    parameter int CNT_W    = 32,
    localparam int BLK_W   = $clog2(2*(GROUP_W/32) + 2),
    localparam int ADDR_W  = 1 + ST_W + BLK_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [31:0]                 cfg_wdata,
    input  logic [N_GROUPS*GROUP_W-1:0] grp_in,
    output logic [ACT_W-1:0]            act_out,
    output logic [ST_W-1:0]             cur_state,
    output logic                        armed
);
    logic [GROUP_W-1:0] mask_r  [N_TRIG_ST];
    logic [GROUP_W-1:0] match_r [N_TRIG_ST];
    st_ctrl_t           ctrl_r  [N_TRIG_ST];
    logic [CNT_W-1:0]   tgt_r   [N_TRIG_ST];
    logic               arm_r;
    logic [ST_W-1:0]    st;
    st_ctrl_t           cur;
    logic               hit;

    dts_cfg_regs #(
        .GROUP_W(GROUP_W), .CNT_W(CNT_W), .BLK_W(BLK_W), .ADDR_W(ADDR_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .mask_o(mask_r), .match_o(match_r), .ctrl_o(ctrl_r), .tgt_o(tgt_r),
        .arm_o(arm_r)
    );

    assign cur = ctrl_r[st];

    dts_cond #(
        .N_GROUPS(N_GROUPS), .GROUP_W(GROUP_W)
    ) u_cond (
        .grp_in(grp_in), .gsel(cur.gsel), .op(cur.op),
        .mask(mask_r[st]), .match(match_r[st]), .hit(hit)
    );

    dts_seq_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .arm(arm_r), .hit(hit),
        .mode(cur.mode), .nxt_st(cur.nxt_st), .tmo_st(cur.tmo_st),
        .act_cfg(cur.act), .target(tgt_r[st]),
        .state_q(st), .act_q(act_out)
    );

    assign cur_state = st;
    assign armed     = arm_r;
endmodule

// File: tb/dbg_trig_seq_tb_top.sv
`timescale 1ns/1ps
module dbg_trig_seq_tb_top;
    localparam int NG = 12;
    localparam int GW = 128;
    localparam logic [127:0] BASE = {4{32'h89AB_CDEF}};
    localparam logic [127:0] FILL = ~BASE;
    localparam logic [127:0] MSK  = {{112{1'b1}}, 16'h0000};

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_we = 1'b0;
    logic [6:0]     cfg_addr = '0;
    logic [31:0]    cfg_wdata = '0;
    logic [NG*GW-1:0] grp = '0;
    logic [7:0]     act_out;
    logic [1:0]     cur_state;
    logic           armed;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dbg_trig_seq dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .grp_in(grp), .act_out(act_out),
        .cur_state(cur_state), .armed(armed)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] mk_ctrl(int g, int op, int mode, int nxt, int tmo, int act);
        return (32'(act) << 13) | (32'(tmo) << 11) | (32'(nxt) << 9) |
               (32'(mode) << 7) | (32'(op) << 4) | 32'(g);
    endfunction

    task automatic wr_state(int s, logic [127:0] m, logic [127:0] v, logic [31:0] c, logic [31:0] t);
        for (int w = 0; w < 4; w++) begin
            wr(7'(s*16 + w), m[w*32 +: 32]);
            wr(7'(s*16 + 4 + w), v[w*32 +: 32]);
        end
        wr(7'(s*16 + 8), c);
        wr(7'(s*16 + 9), t);
    endtask

    task automatic set_all(logic [127:0] v);
        for (int g = 0; g < NG; g++) grp[g*GW +: GW] = v;
    endtask

    task automatic disarm();
        wr(7'h40, 32'h0);
        tick(1);
    endtask

    function automatic bit ref_cmp(int op, logic [127:0] a, logic [127:0] b);
        case (op)
            0: return a == b;
            1: return a != b;
            2: return a > b;
            3: return a >= b;
            4: return a < b;
            5: return a <= b;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] vals [4];
        vals[0] = BASE;
        vals[1] = BASE + (128'h1 << 16);
        vals[2] = BASE - (128'h1 << 16);
        vals[3] = BASE ^ 128'hFFFF;
        set_all(FILL);
        tick(3);
        rst = 1'b0;
        tick(1);
        // R10 reset state
        chk("R10 reset state", 32'(cur_state), 0);
        chk("R10 reset armed", 32'(armed), 0);
        chk("R9 reset act", 32'(act_out), 0);

        // R1 arm bit via global word
        wr(7'h40, 32'h1);
        chk("R1 arm readback", 32'(armed), 1);
        disarm();
        chk("R1 disarm readback", 32'(armed), 0);

        // R3 operator sweep on masked group 0
        wr_state(1, '0, '0, mk_ctrl(0, 7, 0, 0, 0, 8'h22), 0);
        wr_state(0, MSK, BASE, mk_ctrl(0, 0, 0, 1, 0, 8'h11), 0);
        for (int op = 0; op < 8; op++) begin
            wr(7'd8, mk_ctrl(0, op, 0, 1, 0, 8'h11));
            for (int k = 0; k < 4; k++) begin
                grp[0 +: GW] = vals[k];
                wr(7'h40, 32'h1);
                tick(1);
                chk($sformatf("R3 op%0d val%0d", op, k), 32'(cur_state),
                    ref_cmp(op, vals[k] & MSK, BASE & MSK) ? 1 : 0);
                disarm();
            end
        end

        // R2 group select: only group 5 carries the match value
        set_all(FILL);
        grp[5*GW +: GW] = BASE;
        for (int g = 0; g < 16; g++) begin
            wr(7'd8, mk_ctrl(g, 0, 0, 1, 0, 0));
            wr(7'h40, 32'h1);
            tick(1);
            chk($sformatf("R2 sel %0d", g), 32'(cur_state), (g == 5) ? 1 : 0);
            disarm();
        end

        // R4/R9 loop 0->1->2->0 with always-true compare (mask zero)
        wr_state(0, '0, '0, mk_ctrl(0, 0, 0, 1, 0, 8'h01), 0);
        wr_state(1, '0, '0, mk_ctrl(0, 0, 0, 2, 0, 8'h02), 0);
        wr_state(2, '0, '0, mk_ctrl(0, 0, 0, 0, 0, 8'h04), 0);
        wr(7'h40, 32'h1);
        chk("R9 first armed act", 32'(act_out), 0);
        tick(1); chk("R4 loop s1", 32'(cur_state), 1); chk("R9 act s0", 32'(act_out), 8'h01);
        tick(1); chk("R4 loop s2", 32'(cur_state), 2); chk("R9 act s1", 32'(act_out), 8'h02);
        tick(1); chk("R4 loop back s0", 32'(cur_state), 0); chk("R9 act s2", 32'(act_out), 8'h04);
        tick(1); chk("R4 loop s1 again", 32'(cur_state), 1); chk("R9 act s0 again", 32'(act_out), 8'h01);
        disarm();
        chk("R8 disarm state", 32'(cur_state), 0);
        chk("R8 disarm act", 32'(act_out), 0);
        tick(5);
        chk("R8 ignore while disarmed", 32'(cur_state), 0);
        chk("R8 act quiet while disarmed", 32'(act_out), 0);

        // R5 event count: state0 target 3, state1 target 2 back to 0
        set_all(FILL);
        wr_state(0, {128{1'b1}}, BASE, mk_ctrl(0, 0, 1, 1, 0, 0), 3);
        wr_state(1, {128{1'b1}}, BASE, mk_ctrl(0, 0, 1, 0, 0, 0), 2);
        wr(7'h40, 32'h1);
        for (int i = 0; i < 5; i++) begin
            grp[0 +: GW] = (i % 2 == 0) ? BASE : FILL;
            tick(1);
            chk($sformatf("R5 event edge %0d", i), 32'(cur_state), (i == 4) ? 1 : 0);
        end
        grp[0 +: GW] = BASE;
        tick(1); chk("R5 cleared on entry, 1 of 2", 32'(cur_state), 1);
        tick(1); chk("R5 second state target reached", 32'(cur_state), 0);
        disarm();

        // R6 cycle count: target 5 to state 2, compare result ignored
        grp[0 +: GW] = FILL;
        wr_state(0, {128{1'b1}}, BASE, mk_ctrl(0, 0, 2, 2, 0, 0), 5);
        wr_state(2, '0, '0, mk_ctrl(0, 7, 0, 0, 0, 8'h80), 0);
        wr(7'h40, 32'h1);
        for (int i = 0; i < 5; i++) begin
            tick(1);
            chk($sformatf("R6 cycle edge %0d", i), 32'(cur_state), (i == 4) ? 2 : 0);
        end
        tick(1); chk("R9 act after cycle move", 32'(act_out), 8'h80);
        // R8 disarm from a later state
        disarm();
        chk("R8 disarm from s2", 32'(cur_state), 0);
        chk("R8 act cleared", 32'(act_out), 0);

        // R7 watchdog: timeout path, target 4 -> state 3
        wr_state(0, {128{1'b1}}, BASE, mk_ctrl(0, 0, 3, 1, 3, 0), 4);
        wr_state(3, '0, '0, mk_ctrl(0, 7, 0, 0, 0, 0), 0);
        wr(7'h40, 32'h1);
        for (int i = 0; i < 4; i++) begin
            tick(1);
            chk($sformatf("R7 wdog edge %0d", i), 32'(cur_state), (i == 3) ? 3 : 0);
        end
        disarm();
        // R7 watchdog: match before timeout goes to the normal target
        wr(7'h40, 32'h1);
        tick(1); chk("R7 no match yet", 32'(cur_state), 0);
        grp[0 +: GW] = BASE;
        tick(1); chk("R7 match wins", 32'(cur_state), 1);
        disarm();
        // R7 match on the timeout edge still takes the normal target
        grp[0 +: GW] = FILL;
        wr(7'h40, 32'h1);
        tick(3); chk("R7 before limit", 32'(cur_state), 0);
        grp[0 +: GW] = BASE;
        tick(1); chk("R7 match on limit edge", 32'(cur_state), 1);
        disarm();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule